// File: doc/BRIEF.md
# Serial Run-Length Monitor

This block watches a recovered serial bit stream, taking one bit per clock whenever a valid strobe is high. It measures how many consecutive bits share the same level and reports that number. It also keeps the longest run seen since the last clear, and raises a sticky flag once any run grows past a configurable legal limit. Legitimate traffic can already produce runs of up to 26 identical bits, so that limit defaults to 26.

Two stress waveforms are recognised from the sequence of completed runs. The first is the equalizer stress pattern: a run of 19 bits, then a single bit of the opposite level, repeated. The second is the loop-lock stress pattern: runs of 20 bits that alternate in level. Each pattern needs a configurable number of unbroken repeats before its sticky flag sets. A polarity bit is latched beside each flag. A synchronous clear restarts every statistic. Occasional long runs do not disturb the monitor; they only reset the pattern counting.

Top module: `srm_top`

## Requirements
- R1: Each accepted bit of the same level as the current run increases `cur_run` by one. The first accepted bit after reset or clear sets it to 1, and a bit of the other level restarts it at 1. `cur_level` shows the level of the current run (1 = high).
- R2: `cur_run` saturates at 2^RUN_W-1 (255 by default) and never wraps.
- R3: `max_run` holds the largest `cur_run` value reached since the last clear or reset, and is never below `cur_run`.
- R4: A clock with `bit_vld` low and `clr` low changes no output, whatever `bit_in` does.
- R5: Reset and a `clr` pulse set `cur_run`, `max_run`, `over_limit`, and both detection flags and polarity bits to 0. `clr` wins over a valid bit in the same clock; that bit is dropped.
- R6: `over_limit` sets, and stays set until clear, once a run reaches RUN_LIMIT+1 bits. A run of exactly RUN_LIMIT bits leaves it low.
- R7: One equalizer period is a run of 19 bits followed by a run of exactly 1 bit. The period counts when the bit that ends its 1-bit run is accepted. After REPEATS consecutive periods, `eq_det` rises on that edge, and `eq_pol` latches the level of the 19-bit runs (1 = high).
- R8: One loop-lock period is a run of 20 bits followed by a run of 20 bits. The period counts when the bit ending its second run is accepted. After REPEATS consecutive periods, `pll_det` rises on that edge, and `pll_pol` latches the level of the first run of each period.
- R9: Any completed run whose length does not fit the expected place in a pattern restarts that pattern's repeat count. Near misses such as 18+1 or 21-by-21 runs never set a flag.
- R10: `eq_det`, `pll_det` and their polarity bits hold their values until a clear, whatever bits follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all statistics |
| bit_vld | input | 1 | Qualifies `bit_in` on this clock |
| bit_in | input | 1 | Recovered serial bit |
| cur_run | output | RUN_W | Length of the run in progress |
| cur_level | output | 1 | Level of the run in progress |
| max_run | output | RUN_W | Longest run since clear |
| over_limit | output | 1 | Sticky: a run exceeded RUN_LIMIT |
| eq_det | output | 1 | Sticky: equalizer pattern detected |
| eq_pol | output | 1 | Level of the 19-bit runs at detection |
| pll_det | output | 1 | Sticky: alternating 20-bit pattern detected |
| pll_pol | output | 1 | Level of the leading 20-bit run at detection |

## Verification
The bench builds the monitor with REPEATS lowered to 4 and every other parameter at its default. Keeping an 8-bit run counter and a limit of 26 lets a single 300-bit run push the counter into saturation. It also lets runs of 26 and 27 straddle the limit. The short repeat count makes full detection, polarity and near-miss sequences for both patterns take only a few hundred bits each. It also lets a sequence broken one period short be followed by a fresh, complete one.

// File: rtl/srm_pkg.sv
package srm_pkg;
   typedef enum int {
      DET_EQ  = 0,
      DET_PLL = 1
   } det_sel_e;

   localparam int DET_COUNT = 2;
endpackage

// File: rtl/srm_run_tracker.sv
module srm_run_tracker #(
   parameter int RUN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             bit_vld,
   input  logic             bit_in,
   output logic [RUN_W-1:0] run_len_q,
   output logic [RUN_W-1:0] run_len_d,
   output logic             level_q,
   output logic             end_evt,
   output logic [RUN_W-1:0] end_len,
   output logic             end_lvl
);
   localparam logic [RUN_W-1:0] SAT = {RUN_W{1'b1}};

   logic level_d;
   logic started;

   assign started = (run_len_q != '0);
   assign end_len = run_len_q;
   assign end_lvl = level_q;

   always_comb begin
      run_len_d = run_len_q;
      level_d   = level_q;
      end_evt   = 1'b0;
      if (clr) begin
         run_len_d = '0;
         level_d   = 1'b0;
      end else if (bit_vld) begin
         if (started && (bit_in == level_q)) begin
            run_len_d = (run_len_q == SAT) ? SAT : run_len_q + 1'b1;
         end else begin
            end_evt   = started;
            run_len_d = {{(RUN_W-1){1'b0}}, 1'b1};
            level_d   = bit_in;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len_q <= '0;
         level_q   <= 1'b0;
      end else begin
         run_len_q <= run_len_d;
         level_q   <= level_d;
      end
   end
endmodule

// File: rtl/srm_run_stats.sv
module srm_run_stats #(
   parameter int RUN_W     = 8,
   parameter int RUN_LIMIT = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [RUN_W-1:0] run_len_d,
   output logic [RUN_W-1:0] max_q,
   output logic             over_q
);
   localparam logic [RUN_W-1:0] LIMIT = RUN_W'(RUN_LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         max_q  <= '0;
         over_q <= 1'b0;
      end else if (clr) begin
         max_q  <= '0;
         over_q <= 1'b0;
      end else begin
         if (run_len_d > max_q) max_q <= run_len_d;
         if (run_len_d > LIMIT) over_q <= 1'b1;
      end
   end
endmodule

// File: rtl/srm_pattern_det.sv
module srm_pattern_det #(
   parameter int RUN_W     = 8,
   parameter int LONG_LEN  = 19,
   parameter int SHORT_LEN = 1,
   parameter int REPEATS   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             end_evt,
   input  logic [RUN_W-1:0] end_len,
   input  logic             end_lvl,
   output logic             det_q,
   output logic             pol_q
);
   localparam int CNT_W = $clog2(REPEATS + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REPEATS);
   localparam logic [RUN_W-1:0] L_LEN = RUN_W'(LONG_LEN);
   localparam logic [RUN_W-1:0] S_LEN = RUN_W'(SHORT_LEN);

   logic             armed_q, armed_d;
   logic             long_lvl_q, long_lvl_d;
   logic             seq_pol_q, seq_pol_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             det_d, pol_d;

   always_comb begin
      armed_d    = armed_q;
      long_lvl_d = long_lvl_q;
      seq_pol_d  = seq_pol_q;
      cnt_d      = cnt_q;
      det_d      = det_q;
      pol_d      = pol_q;
      if (clr) begin
         armed_d    = 1'b0;
         long_lvl_d = 1'b0;
         seq_pol_d  = 1'b0;
         cnt_d      = '0;
         det_d      = 1'b0;
         pol_d      = 1'b0;
      end else if (end_evt) begin
         if (armed_q && (end_len == S_LEN)) begin
            armed_d   = 1'b0;
            seq_pol_d = long_lvl_q;
            if ((cnt_q == '0) || (seq_pol_q != long_lvl_q))
               cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
            else if (cnt_q != CNT_MAX)
               cnt_d = cnt_q + 1'b1;
            if ((cnt_d == CNT_MAX) && !det_q) begin
               det_d = 1'b1;
               pol_d = long_lvl_q;
            end
         end else if (end_len == L_LEN) begin
            armed_d    = 1'b1;
            long_lvl_d = end_lvl;
            if (armed_q) cnt_d = '0;
         end else begin
            armed_d = 1'b0;
            cnt_d   = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         long_lvl_q <= 1'b0;
         seq_pol_q  <= 1'b0;
         cnt_q      <= '0;
         det_q      <= 1'b0;
         pol_q      <= 1'b0;
      end else begin
         armed_q    <= armed_d;
         long_lvl_q <= long_lvl_d;
         seq_pol_q  <= seq_pol_d;
         cnt_q      <= cnt_d;
         det_q      <= det_d;
         pol_q      <= pol_d;
      end
   end
endmodule

// File: rtl/srm_top.sv
module srm_top #(
   parameter int RUN_W     = 8,
   parameter int RUN_LIMIT = 26,
   parameter int EQ_LONG   = 19,
   parameter int EQ_SHORT  = 1,
   parameter int PLL_LONG  = 20,
   parameter int PLL_SHORT = 20,
   parameter int REPEATS   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             bit_vld,
   input  logic             bit_in,
   output logic [RUN_W-1:0] cur_run,
   output logic             cur_level,
   output logic [RUN_W-1:0] max_run,
   output logic             over_limit,
   output logic             eq_det,
   output logic             eq_pol,
   output logic             pll_det,
   output logic             pll_pol
);
   import srm_pkg::*;

   localparam int SAT_VAL = (1 << RUN_W) - 1;

   if (RUN_W < 2 || RUN_W > 16) begin : g_bad_width
      $error("srm_top: RUN_W must be within 2..16");
   end
   if (REPEATS < 1) begin : g_bad_rep
      $error("srm_top: REPEATS must be at least 1");
   end
   if (EQ_LONG >= SAT_VAL || PLL_LONG >= SAT_VAL || RUN_LIMIT >= SAT_VAL) begin : g_bad_len
      $error("srm_top: pattern lengths and limit must stay below saturation");
   end
   if (EQ_SHORT < 1 || PLL_SHORT < 1 || EQ_SHORT >= SAT_VAL || PLL_SHORT >= SAT_VAL) begin : g_bad_short
      $error("srm_top: short run lengths must be within 1..saturation-1");
   end

   logic [RUN_W-1:0] run_len_d;
   logic             end_evt;
   logic [RUN_W-1:0] end_len;
   logic             end_lvl;
   logic [DET_COUNT-1:0] det_vec;
   logic [DET_COUNT-1:0] pol_vec;

   srm_run_tracker #(.RUN_W(RUN_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .bit_vld   (bit_vld),
      .bit_in    (bit_in),
      .run_len_q (cur_run),
      .run_len_d (run_len_d),
      .level_q   (cur_level),
      .end_evt   (end_evt),
      .end_len   (end_len),
      .end_lvl   (end_lvl)
   );

   srm_run_stats #(.RUN_W(RUN_W), .RUN_LIMIT(RUN_LIMIT)) u_stats (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .run_len_d (run_len_d),
      .max_q     (max_run),
      .over_q    (over_limit)
   );

   for (genvar gi = 0; gi < DET_COUNT; gi++) begin : g_det
      localparam int LNG = (gi == int'(DET_EQ)) ? EQ_LONG  : PLL_LONG;
      localparam int SHT = (gi == int'(DET_EQ)) ? EQ_SHORT : PLL_SHORT;
      srm_pattern_det #(
         .RUN_W     (RUN_W),
         .LONG_LEN  (LNG),
         .SHORT_LEN (SHT),
         .REPEATS   (REPEATS)
      ) u_det (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clr),
         .end_evt (end_evt),
         .end_len (end_len),
         .end_lvl (end_lvl),
         .det_q   (det_vec[gi]),
         .pol_q   (pol_vec[gi])
      );
   end

   assign eq_det  = det_vec[int'(DET_EQ)];
   assign eq_pol  = pol_vec[int'(DET_EQ)];
   assign pll_det = det_vec[int'(DET_PLL)];
   assign pll_pol = pol_vec[int'(DET_PLL)];
endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
   parameter int RUN_W     = 8,
   parameter int RUN_LIMIT = 26
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             bit_vld,
   input logic             bit_in,
   input logic [RUN_W-1:0] cur_run,
   input logic             cur_level,
   input logic [RUN_W-1:0] max_run,
   input logic             over_limit,
   input logic             eq_det,
   input logic             eq_pol,
   input logic             pll_det,
   input logic             pll_pol
);
   localparam logic [RUN_W-1:0] SAT = {RUN_W{1'b1}};

   // R1: same-level bit grows the run by one
   a_r1_grow: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && !clr && cur_run != '0 && cur_run != SAT && bit_in == cur_level)
      |=> cur_run == $past(cur_run) + 1'b1);

   // R2: saturated run stays saturated
   a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && !clr && cur_run == SAT && bit_in == cur_level) |=> cur_run == SAT);

   // R3
   a_r3_max_ge_cur: assert property (@(posedge clk) disable iff (!rst_n)
      max_run >= cur_run);

   // R4
   a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_vld && !clr) |=> ($stable(cur_run) && $stable(max_run) && $stable(over_limit)
                              && $stable(eq_det) && $stable(pll_det) && $stable(cur_level)));

   // R5
   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cur_run == '0 && max_run == '0 && !over_limit && !eq_det && !pll_det
               && !eq_pol && !pll_pol));

   // R6
   a_r6_over: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_run > RUN_W'(RUN_LIMIT)) |-> over_limit);

   // R10
   a_r10_eq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (eq_det && !clr) |=> (eq_det && $stable(eq_pol)));

   a_r10_pll_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_det && !clr) |=> (pll_det && $stable(pll_pol)));
endmodule

bind srm_top srm_checker #(.RUN_W(RUN_W), .RUN_LIMIT(RUN_LIMIT)) u_srm_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr        (clr),
   .bit_vld    (bit_vld),
   .bit_in     (bit_in),
   .cur_run    (cur_run),
   .cur_level  (cur_level),
   .max_run    (max_run),
   .over_limit (over_limit),
   .eq_det     (eq_det),
   .eq_pol     (eq_pol),
   .pll_det    (pll_det),
   .pll_pol    (pll_pol)
);

// File: tb/srm_top_bench.sv
`timescale 1ns/1ps
module srm_top_bench;
   localparam int RUN_W = 8;
   localparam int REP   = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clr = 1'b0;
   logic             bit_vld = 1'b0;
   logic             bit_in = 1'b0;
   logic [RUN_W-1:0] cur_run;
   logic             cur_level;
   logic [RUN_W-1:0] max_run;
   logic             over_limit;
   logic             eq_det, eq_pol, pll_det, pll_pol;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   srm_top #(.REPEATS(REP)) u_srm_top (
      .clk(clk), .rst_n(rst_n), .clr(clr), .bit_vld(bit_vld), .bit_in(bit_in),
      .cur_run(cur_run), .cur_level(cur_level), .max_run(max_run),
      .over_limit(over_limit), .eq_det(eq_det), .eq_pol(eq_pol),
      .pll_det(pll_det), .pll_pol(pll_pol)
   );

   // {level, length[8:0], exp_cur[7:0], exp_max[7:0], exp_over}
   localparam int NVEC = 6;
   localparam logic [26:0] VEC [NVEC] = '{
      {1'b1, 9'd5,   8'd5,   8'd5,   1'b0},
      {1'b0, 9'd26,  8'd26,  8'd26,  1'b0},
      {1'b1, 9'd3,   8'd3,   8'd26,  1'b0},
      {1'b0, 9'd27,  8'd27,  8'd27,  1'b1},
      {1'b1, 9'd300, 8'd255, 8'd255, 1'b1},
      {1'b0, 9'd2,   8'd2,   8'd255, 1'b1}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic lvl, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_vld = 1'b1;
         bit_in  = lvl;
      end
      @(negedge clk);
      bit_vld = 1'b0;
   endtask

   task automatic do_clear();
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R5 reset state
      chk("R5 reset cur_run", int'(cur_run), 0);
      chk("R5 reset max_run", int'(max_run), 0);
      chk("R5 reset flags", int'({over_limit, eq_det, pll_det}), 0);
      rst_n = 1'b1;
      do_clear();

      // R1 R2 R3 R6 table walk
      for (int v = 0; v < NVEC; v++) begin
         drive(VEC[v][26], int'(VEC[v][25:17]));
         chk("R1/R2 cur_run", int'(cur_run), int'(VEC[v][16:9]));
         chk("R1 cur_level", int'(cur_level), int'(VEC[v][26]));
         chk("R3 max_run", int'(max_run), int'(VEC[v][8:1]));
         chk("R6 over_limit", int'(over_limit), int'(VEC[v][0]));
      end

      // R4 idle bits ignored
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         bit_vld = 1'b0;
         bit_in  = ~bit_in;
      end
      @(negedge clk);
      chk("R4 cur_run idle", int'(cur_run), 2);
      chk("R4 max_run idle", int'(max_run), 255);

      // R5 clear beats a valid bit
      @(negedge clk);
      clr = 1'b1; bit_vld = 1'b1; bit_in = 1'b0;
      @(negedge clk);
      clr = 1'b0; bit_vld = 1'b0;
      chk("R5 clr cur_run", int'(cur_run), 0);
      chk("R5 clr max_run", int'(max_run), 0);
      chk("R5 clr over", int'(over_limit), 0);

      // R7 equalizer, high polarity
      for (int p = 0; p < REP; p++) begin drive(1'b1, 19); drive(1'b0, 1); end
      chk("R7 eq not yet", int'(eq_det), 0);
      drive(1'b1, 1);
      chk("R7 eq_det high", int'(eq_det), 1);
      chk("R7 eq_pol high", int'(eq_pol), 1);
      chk("R8 no pll on eq", int'(pll_det), 0);
      // R10 sticky
      drive(1'b1, 6); drive(1'b0, 5); drive(1'b1, 7);
      chk("R10 eq sticky", int'(eq_det), 1);
      chk("R10 eq_pol sticky", int'(eq_pol), 1);

      // R7 equalizer, low polarity
      do_clear();
      for (int p = 0; p < REP; p++) begin drive(1'b0, 19); drive(1'b1, 1); end
      drive(1'b0, 1);
      chk("R7 eq_det low", int'(eq_det), 1);
      chk("R7 eq_pol low", int'(eq_pol), 0);

      // R8 alternating 20-bit runs
      do_clear();
      for (int p = 0; p < REP; p++) begin drive(1'b1, 20); drive(1'b0, 20); end
      chk("R8 pll not yet", int'(pll_det), 0);
      drive(1'b1, 1);
      chk("R8 pll_det", int'(pll_det), 1);
      chk("R8 pll_pol", int'(pll_pol), 1);
      chk("R7 no eq on pll", int'(eq_det), 0);

      // R9 near misses
      do_clear();
      for (int p = 0; p < REP + 2; p++) begin drive(1'b1, 18); drive(1'b0, 1); end
      drive(1'b1, 1);
      chk("R9 18+1 no eq", int'(eq_det), 0);
      do_clear();
      for (int p = 0; p < REP + 2; p++) begin drive(1'b1, 21); drive(1'b0, 21); end
      drive(1'b1, 1);
      chk("R9 21x21 no pll", int'(pll_det), 0);

      // R9 broken sequence restarts the count
      do_clear();
      for (int p = 0; p < REP - 1; p++) begin drive(1'b1, 19); drive(1'b0, 1); end
      drive(1'b1, 5); drive(1'b0, 1);
      for (int p = 0; p < REP - 1; p++) begin drive(1'b1, 19); drive(1'b0, 1); end
      drive(1'b1, 1);
      chk("R9 broken eq", int'(eq_det), 0);
      drive(1'b1, 18); drive(1'b0, 1); drive(1'b1, 1);
      chk("R9 eq after restart", int'(eq_det), 1);

      finish_run();
   end
endmodule